// File: doc/BRIEF.md
# Passive Latch-Clock-Data Frame Sniffer

This block listens to a three-wire serial bus made of a latch line, a bus clock line and a data line. It only receives: all three wires are inputs, and nothing is ever driven back toward the bus. The bus wires are asynchronous to the fast system clock, so each one passes through a multi-flop synchronizer. Falling edges are then found by comparing each synchronized level with its value one system cycle earlier.

A falling edge on the latch line opens a frame, and the data level seen at that instant becomes sample 0. Each of the next seven bus-clock falling edges adds one more sample. After the last sample the block goes idle and waits for the next latch edge. A latch edge in the middle of a frame throws the partial frame away and starts again at sample 0. Bus-clock edges seen while idle do nothing.

When a frame is complete, the eight samples are inverted and loaded into a parallel output register. A one-cycle valid strobe marks the load for downstream logic such as a packet formatter. The outputs keep their value until the next complete frame.

Top module: `lcd_frame_sniffer`

## Requirements
- R1: A falling edge on `bus_latch` starts a frame, and the `bus_data` level present at that edge is taken as sample 0.
- R2: Samples 1 to 7 are taken from `bus_data` on the next seven falling edges of `bus_clk`, in order.
- R3: A frame holds exactly 8 samples. Once the eighth sample is taken, further `bus_clk` falling edges are ignored until the next `bus_latch` falling edge.
- R4: `frame_bits[i]` equals the logical inverse of sample i, for i from 0 to 7 (bit 0 comes from the latch edge and bit 7 from the seventh clock edge).
- R5: `frame_bits` changes only when a full 8-sample frame completes. At all other times, including after partial frames, it holds its value.
- R6: `frame_valid` is high for exactly one system clock, in the cycle in which `frame_bits` takes the new frame. It gives one pulse per completed frame.
- R7: A `bus_latch` falling edge during a frame discards the partial samples and restarts capture at sample 0. The partial frame never reaches the outputs.
- R8: While the synchronous active-high `rst` is held, `frame_bits` is all ones, `frame_valid` is low, and the sequencer is idle.
- R9: A `bus_clk` falling edge that arrives while no frame is open changes neither the outputs nor the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_latch | input | 1 | Observed latch wire (asynchronous) |
| bus_clk | input | 1 | Observed bus clock wire (asynchronous) |
| bus_data | input | 1 | Observed data wire (asynchronous) |
| frame_bits | output | 8 | Inverted samples of the last complete frame |
| frame_valid | output | 1 | One-cycle strobe when frame_bits is loaded |

## Verification
A wrong sample counter shows up at the ports within one frame. The valid pulse arrives after the wrong number of bus-clock edges, or never arrives, and the output pattern comes out shifted. A sequencer that fails to leave idle, or that fails to restart on a mid-frame latch, gives either a missing strobe or a pattern that mixes two frames. The bench catches this within a few system cycles after the frame is expected. Stray strobes or output changes after ignored clock edges are visible right after those edges, because the outputs are checked at that point before the next latch.

// File: rtl/lcd_sniff_pkg.sv
package lcd_sniff_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

   // Value held by the output register out of reset: the output image of
   // an all-zero frame.
   function automatic logic [63:0] idle_image(input int unsigned width,
                                              input bit invert);
      logic [63:0] v;
      v = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < int'(width)) v[i] = invert;
      end
      return v;
   endfunction

endpackage

// File: rtl/snf_sync.sv
module snf_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("snf_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("snf_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/snf_edge.sv
module snf_edge #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fall
);

   logic [WIDTH-1:0] prev_q;

   // prev clears to zero so that no falling edge can be reported in the
   // first cycle after reset, whatever level the bus sits at.
   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= level;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_det
      assign fall[i] = prev_q[i] & ~level[i];
   end

endmodule

// File: rtl/snf_seq.sv
module snf_seq
   import lcd_sniff_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  latch_fall,
   input  logic                  clk_fall,
   input  logic                  data_lvl,
   output logic                  seq_busy,
   output logic [CNT_W-1:0]      bit_cnt,
   output logic                  frame_done,
   output logic [FRAME_BITS-1:0] frame_word
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   seq_state_e            state_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [FRAME_BITS-1:0] shreg_q;
   logic                  take_bit;

   assign take_bit = (state_q == SEQ_BUSY) && clk_fall && !latch_fall;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (latch_fall) begin
         // A latch edge always wins: open or reopen the frame at sample 0.
         state_q    <= SEQ_BUSY;
         cnt_q      <= ONE;
         shreg_q    <= '0;
         shreg_q[0] <= data_lvl;
      end else if (take_bit) begin
         shreg_q[cnt_q] <= data_lvl;
         if (cnt_q == LAST_IDX) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   assign frame_done = take_bit && (cnt_q == LAST_IDX);

   always_comb begin
      frame_word           = shreg_q;
      frame_word[LAST_IDX] = data_lvl;
   end

   assign seq_busy = (state_q == SEQ_BUSY);
   assign bit_cnt  = cnt_q;

endmodule

// File: rtl/snf_outreg.sv
module snf_outreg
   import lcd_sniff_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   parameter bit OUT_INVERT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] word,
   output logic [FRAME_BITS-1:0] bits,
   output logic                  valid
);

   localparam logic [63:0] IDLE_FULL = idle_image(FRAME_BITS, OUT_INVERT);
   localparam logic [FRAME_BITS-1:0] IDLE_VAL = IDLE_FULL[FRAME_BITS-1:0];

   logic [FRAME_BITS-1:0] image;

   if (OUT_INVERT) begin : g_inv
      assign image = ~word;
   end else begin : g_pass
      assign image = word;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bits  <= IDLE_VAL;
         valid <= 1'b0;
      end else begin
         valid <= load;
         if (load) bits <= image;
      end
   end

endmodule

// File: rtl/lcd_frame_sniffer.sv
module lcd_frame_sniffer
   import lcd_sniff_pkg::*;
#(
   parameter int FRAME_BITS  = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_INVERT  = 1'b1,
   localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bus_latch,
   input  logic                  bus_clk,
   input  logic                  bus_data,
   output logic [FRAME_BITS-1:0] frame_bits,
   output logic                  frame_valid
);

   if (FRAME_BITS < 2 || FRAME_BITS > 64) begin : g_bad_frame
      $error("lcd_frame_sniffer: FRAME_BITS must lie in 2..64");
   end

   localparam int LANES = 3;
   localparam int L_LATCH = 0;
   localparam int L_CLK   = 1;
   localparam int L_DATA  = 2;

   logic [LANES-1:0]      raw_lvl;
   logic [LANES-1:0]      sync_lvl;
   logic [1:0]            falls;
   logic                  latch_fall;
   logic                  clk_fall;
   logic                  seq_busy;
   logic [CNT_W-1:0]      bit_cnt;
   logic                  frame_done;
   logic [FRAME_BITS-1:0] frame_word;

   assign raw_lvl[L_LATCH] = bus_latch;
   assign raw_lvl[L_CLK]   = bus_clk;
   assign raw_lvl[L_DATA]  = bus_data;

   snf_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_lvl),
      .dout (sync_lvl)
   );

   snf_edge #(.WIDTH(2)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .level ({sync_lvl[L_CLK], sync_lvl[L_LATCH]}),
      .fall  (falls)
   );

   assign latch_fall = falls[0];
   assign clk_fall   = falls[1];

   snf_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .latch_fall (latch_fall),
      .clk_fall   (clk_fall),
      .data_lvl   (sync_lvl[L_DATA]),
      .seq_busy   (seq_busy),
      .bit_cnt    (bit_cnt),
      .frame_done (frame_done),
      .frame_word (frame_word)
   );

   snf_outreg #(.FRAME_BITS(FRAME_BITS), .OUT_INVERT(OUT_INVERT)) u_out (
      .clk   (clk),
      .rst   (rst),
      .load  (frame_done),
      .word  (frame_word),
      .bits  (frame_bits),
      .valid (frame_valid)
   );

endmodule

// File: rtl/snf_checker.sv
module snf_checker
   import lcd_sniff_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   parameter bit OUT_INVERT = 1'b1,
   localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  latch_fall,
   input logic                  clk_fall,
   input logic                  seq_busy,
   input logic [CNT_W-1:0]      bit_cnt,
   input logic                  frame_done,
   input logic [FRAME_BITS-1:0] frame_word,
   input logic [FRAME_BITS-1:0] frame_bits,
   input logic                  frame_valid
);

   localparam logic [63:0] IDLE_FULL = idle_image(FRAME_BITS, OUT_INVERT);
   localparam logic [FRAME_BITS-1:0] IDLE_VAL = IDLE_FULL[FRAME_BITS-1:0];

   // R8: the cycle after a reset edge shows the idle output image
   a_r8_reset_state: assert property (@(posedge clk)
      rst |=> (frame_bits == IDLE_VAL && !frame_valid && !seq_busy));

   // R1: a latch edge opens the frame with one sample held
   a_r1_latch_opens: assert property (@(posedge clk) disable iff (rst)
      latch_fall |=> (seq_busy && bit_cnt == CNT_W'(1)));

   // R7: a latch edge inside a frame restarts it and suppresses the strobe
   a_r7_restart: assert property (@(posedge clk) disable iff (rst)
      (seq_busy && latch_fall) |=> (bit_cnt == CNT_W'(1) && !frame_valid));

   // R3: the sample count stays inside the frame while busy
   a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
      seq_busy |-> (bit_cnt >= CNT_W'(1) && bit_cnt < CNT_W'(FRAME_BITS)));

   // R9: idle clock edges leave the sequencer idle and give no strobe
   a_r9_idle_clock: assert property (@(posedge clk) disable iff (rst)
      (!seq_busy && clk_fall && !latch_fall) |=> (!seq_busy && !frame_valid));

   // R6: the strobe lasts one cycle and follows a completed frame
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      frame_valid |=> !frame_valid);
   a_r6_after_done: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> frame_valid);

   // R5: outputs hold whenever no frame is published
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !frame_valid |-> $stable(frame_bits));

   // R4: published bits are the inverse of the completed samples
   a_r4_inverted: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> (frame_bits == (OUT_INVERT ? ~$past(frame_word)
                                                :  $past(frame_word))));

endmodule

bind lcd_frame_sniffer snf_checker #(
   .FRAME_BITS (FRAME_BITS),
   .OUT_INVERT (OUT_INVERT)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .latch_fall  (latch_fall),
   .clk_fall    (clk_fall),
   .seq_busy    (seq_busy),
   .bit_cnt     (bit_cnt),
   .frame_done  (frame_done),
   .frame_word  (frame_word),
   .frame_bits  (frame_bits),
   .frame_valid (frame_valid)
);

// File: tb/tb_lcd_frame_sniffer.sv
module tb_lcd_frame_sniffer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_latch = 1'b1;
   logic       bus_clk   = 1'b1;
   logic       bus_data  = 1'b0;
   logic [7:0] frame_bits;
   logic       frame_valid;

   int n_vec  = 0;
   int n_bad  = 0;
   int pulses = 0;
   int last_width_bad = 0;
   logic prev_valid = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   lcd_frame_sniffer dut (
      .clk         (clk),
      .rst         (rst),
      .bus_latch   (bus_latch),
      .bus_clk     (bus_clk),
      .bus_data    (bus_data),
      .frame_bits  (frame_bits),
      .frame_valid (frame_valid)
   );

   // Strobe monitor: counts pulses and pulses wider than one cycle.
   always @(posedge clk) begin
      if (!rst) begin
         if (frame_valid) pulses++;
         if (frame_valid && prev_valid) last_width_bad++;
      end
      prev_valid <= frame_valid;
   end

   function automatic logic [7:0] expect_image(input logic [7:0] samples);
      return ~samples;
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic latch_edge(input logic b0);
      bus_data = b0;
      idle(4);
      bus_latch = 1'b0;
      idle(4);
      bus_latch = 1'b1;
      idle(3);
   endtask

   task automatic clock_edge(input logic b);
      bus_data = b;
      idle(4);
      bus_clk = 1'b0;
      idle(4);
      bus_clk = 1'b1;
      idle(3);
   endtask

   task automatic send_frame(input logic [7:0] d);
      latch_edge(d[0]);
      for (int i = 1; i < 8; i++) clock_edge(d[i]);
      idle(6);
   endtask

   task automatic full_check(input string req, input logic [7:0] d,
                             input int pulses_before);
      check(req, frame_bits, expect_image(d));
      check({req, " pulse"}, pulses - pulses_before, 1);
   endtask

   initial begin
      int p0;
      logic [7:0] hold;
      void'($urandom(32'h1A7C_0D5E));
      idle(5);
      // R8: reset state while reset is held
      check("R8 bits", frame_bits, 8'hFF);
      check("R8 valid", frame_valid, 0);
      rst = 1'b0;
      idle(4);
      check("R8 after release", frame_bits, 8'hFF);

      // R1: only the latch-edge sample set
      p0 = pulses; send_frame(8'h01); full_check("R1", 8'h01, p0);
      // R2: top sample from the seventh clock edge
      p0 = pulses; send_frame(8'h80); full_check("R2", 8'h80, p0);
      // R4: extremes and an alternating pattern
      p0 = pulses; send_frame(8'h00); full_check("R4 zero", 8'h00, p0);
      p0 = pulses; send_frame(8'hFF); full_check("R4 ones", 8'hFF, p0);
      p0 = pulses; send_frame(8'hA5); full_check("R4 A5", 8'hA5, p0);

      // R9: idle clock edges change nothing
      p0 = pulses; hold = frame_bits;
      for (int i = 0; i < 10; i++) clock_edge(i[0]);
      idle(4);
      check("R9 bits", frame_bits, hold);
      check("R9 pulse", pulses - p0, 0);

      // R5: partial frame (five samples) leaves outputs alone
      p0 = pulses;
      latch_edge(1'b1);
      for (int i = 0; i < 4; i++) clock_edge(1'b1);
      idle(6);
      check("R5 bits", frame_bits, hold);
      check("R5 pulse", pulses - p0, 0);

      // R7: restart mid-frame; partial 0xFF-ish data must not leak
      p0 = pulses;
      latch_edge(1'b1);
      for (int i = 0; i < 3; i++) clock_edge(1'b1);
      send_frame(8'h3C);
      full_check("R7", 8'h3C, p0);

      // R3: extra clock edges after the frame are ignored
      p0 = pulses;
      for (int i = 0; i < 3; i++) clock_edge(1'b1);
      idle(4);
      check("R3 bits", frame_bits, expect_image(8'h3C));
      check("R3 pulse", pulses - p0, 0);

      // Random frames, with random idle clocks and tails
      for (int k = 0; k < 24; k++) begin
         logic [7:0] d;
         int pre, post;
         d = 8'($urandom);
         pre = $urandom_range(0, 2);
         post = $urandom_range(0, 2);
         for (int j = 0; j < pre; j++) clock_edge(1'($urandom));
         p0 = pulses;
         send_frame(d);
         for (int j = 0; j < post; j++) clock_edge(1'($urandom));
         idle(3);
         full_check("R2 R4 R6 random", d, p0);
      end

      // R6: strobe never wider than one cycle over the whole run
      check("R6 width", last_width_bad, 0);

      // R8: reset mid-run returns outputs to all ones
      rst = 1'b1;
      idle(3);
      check("R8 rerun bits", frame_bits, 8'hFF);
      check("R8 rerun valid", frame_valid, 0);
      rst = 1'b0;
      idle(3);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule